// File: doc/BRIEF.md
# Outbound Address Translation Window Table

This block sits on the outbound path of a PCIe host bridge and maps addresses arriving from the AXI side onto the PCIe address space. It holds up to eight programmable windows. Each window has an enable bit, a transaction type (configuration, I/O or memory), a size held as a mask, a word-aligned AXI base and a 64-bit PCIe base. Software programs the windows through a simple word-wide register write port and can read every register back through a combinational read port.

For every address on the lookup input, the block compares the address against all enabled windows in parallel. It picks the lowest-numbered window that matches, then produces the translated PCIe address and the transaction type. If no window matches, it raises a miss flag. For a configuration window the PCIe base carries a bus, device and function number, and the block also breaks these out of the translated address as separate fields so that downstream request logic does not have to slice them.

Top module: `obw_top`

## Requirements
- R1: After reset, every register reads as zero, every window is disabled and every lookup reports a miss.
- R2: Window w (0 to 7) occupies the 16-byte block at offset 16*w. Within that block, control is at +0x0, AXI base at +0x4, PCIe base bits 31:0 at +0x8 and PCIe base bits 63:32 at +0xC. The upper 32 mask bits of window w are at 0x100 + 4*w. Register address bits 1:0 are not decoded. Writes to any other offset change nothing, and reads from any other offset return zero.
- R3: Bits 1:0 of the AXI base are discarded on write and read back as zero.
- R4: The control register holds the enable in bit 0, the type in bits 2:1 and mask bits 31:12 in bits 31:12. Bits 11:3 read as zero. Mask bits 11:0 are always zero. A window hits when the enable is set and (address AND mask) equals (AXI base AND mask) over the 32 address bits.
- R5: On a hit, the PCIe address equals the 64-bit PCIe base OR (the zero-extended address AND NOT the 64-bit mask).
- R6: When several windows hit, the lowest-numbered one is reported and used, and its index appears on hitWin.
- R7: A window whose enable bit is clear never hits. A window with type 3 (reserved) also never hits.
- R8: When no window hits, miss is 1 and pcieAddr, txnType, hitWin and the three config fields are all zero.
- R9: txnType reports the type of the winning window: 0 for config, 1 for I/O, 2 for memory. For a config hit, cfgBus, cfgDev and cfgFunc equal translated address bits 31:24, 23:19 and 18:16. For any other result these fields are zero.
- R10: Register writes take effect at the clock edge. A lookup in the same cycle as a write sees the contents from before the write, and a lookup in the following cycle sees the new contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | REG_AW | Register byte offset for both read and write |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Combinational read data for regAddr |
| lookupAddr | input | 32 | AXI-side address to translate |
| miss | output | 1 | No enabled window matches lookupAddr |
| hitWin | output | WIDX_W | Index of the winning window |
| pcieAddr | output | 64 | Translated PCIe address |
| txnType | output | 2 | Transaction type of the winning window |
| cfgBus | output | 8 | Bus number for a config hit |
| cfgDev | output | 5 | Device number for a config hit |
| cfgFunc | output | 3 | Function number for a config hit |

## Verification
A register write and a lookup can occur in the same cycle. The outcome of the lookup then depends on whether it sees the contents from before or after the write. The bench provokes this by disabling the currently winning window while the lookup address points into it. It expects the old translation in that cycle and the next-priority window in the following cycle. Overlapping windows, a reserved type, and a lookup just past a window's end test the priority and mask logic against values computed independently from the requirements.

// File: rtl/obw_pkg.sv
`timescale 1ns/1ps
package obw_pkg;

  localparam int OBW_MAX_WIN  = 8;
  localparam int OBW_DW       = 32;
  localparam int OBW_GRAN_W   = 12;                    // mask bits always zero
  localparam int OBW_MASKLO_W = OBW_DW - OBW_GRAN_W;   // stored low mask bits
  localparam int OBW_IDX_W    = $clog2(OBW_MAX_WIN);

  typedef enum logic [1:0] {
    TYP_CFG  = 2'd0,
    TYP_IO   = 2'd1,
    TYP_MEM  = 2'd2,
    TYP_RSVD = 2'd3
  } obwType_e;

  typedef enum logic [2:0] {
    FLD_CTRL,
    FLD_AXI,
    FLD_PLO,
    FLD_PHI,
    FLD_SZHI,
    FLD_NONE
  } obwField_e;

  // strobes from register decode to datapath
  typedef struct packed {
    logic [OBW_MAX_WIN-1:0] ctrlWe;
    logic [OBW_MAX_WIN-1:0] axiWe;
    logic [OBW_MAX_WIN-1:0] loWe;
    logic [OBW_MAX_WIN-1:0] hiWe;
    logic [OBW_MAX_WIN-1:0] szWe;
    obwField_e              rdField;
    logic [OBW_IDX_W-1:0]   rdWin;
  } obwStrobe_t;

  typedef struct packed {
    logic                    en;
    obwType_e                typ;
    logic [OBW_MASKLO_W-1:0] maskLo;
    logic [OBW_DW-3:0]       axiBase;   // word address
    logic [OBW_DW-1:0]       pcieLo;
    logic [OBW_DW-1:0]       pcieHi;
    logic [OBW_DW-1:0]       maskHi;
  } obwWin_t;

endpackage

// File: rtl/obw_regctl.sv
`timescale 1ns/1ps
module obw_regctl
  import obw_pkg::*;
#(
  parameter int NUM_WIN = OBW_MAX_WIN,
  parameter int REG_AW  = 9
) (
  input  logic              regWrEn,
  input  logic [REG_AW-1:0] regAddr,
  output obwStrobe_t        strb
);

  localparam int EXT_BIT   = REG_AW - 1;  // selects the mask-high region
  localparam int BLK_LSB   = 4;           // 16-byte window blocks
  localparam int BLK_W     = EXT_BIT - BLK_LSB;
  localparam int EIDX_W    = EXT_BIT - 2;

  logic [BLK_W-1:0]     blkIdx;
  logic [EIDX_W-1:0]    extIdx;
  logic [OBW_IDX_W-1:0] winSel;
  logic                 unusedLow;

  assign blkIdx    = regAddr[EXT_BIT-1:BLK_LSB];
  assign extIdx    = regAddr[EXT_BIT-1:2];
  assign unusedLow = ^regAddr[1:0];

  always_comb begin
    strb         = '0;
    strb.rdField = FLD_NONE;
    winSel       = '0;
    if (!regAddr[EXT_BIT]) begin
      if (int'(blkIdx) < NUM_WIN) begin
        winSel = blkIdx[OBW_IDX_W-1:0];
        unique case (regAddr[3:2])
          2'd0:    strb.rdField = FLD_CTRL;
          2'd1:    strb.rdField = FLD_AXI;
          2'd2:    strb.rdField = FLD_PLO;
          default: strb.rdField = FLD_PHI;
        endcase
      end
    end else if (int'(extIdx) < NUM_WIN) begin
      winSel       = extIdx[OBW_IDX_W-1:0];
      strb.rdField = FLD_SZHI;
    end
    strb.rdWin = winSel;
    unique case (strb.rdField)
      FLD_CTRL: strb.ctrlWe[winSel] = regWrEn;
      FLD_AXI:  strb.axiWe[winSel]  = regWrEn;
      FLD_PLO:  strb.loWe[winSel]   = regWrEn;
      FLD_PHI:  strb.hiWe[winSel]   = regWrEn;
      FLD_SZHI: strb.szWe[winSel]   = regWrEn;
      default:  ;
    endcase
  end

endmodule

// File: rtl/obw_winmatch.sv
`timescale 1ns/1ps
module obw_winmatch
  import obw_pkg::*;
(
  input  obwWin_t     win,
  input  logic [31:0] addr,
  output logic        hit,
  output logic [63:0] xlat
);

  logic [63:0] mask;
  logic [31:0] baseAddr;
  logic        typOk;

  assign mask     = {win.maskHi, win.maskLo, {OBW_GRAN_W{1'b0}}};
  assign baseAddr = {win.axiBase, 2'b00};
  assign typOk    = (win.typ != TYP_RSVD);
  assign hit      = win.en && typOk && (((addr ^ baseAddr) & mask[31:0]) == '0);
  assign xlat     = {win.pcieHi, win.pcieLo} | ({32'b0, addr} & ~mask);

endmodule

// File: rtl/obw_datapath.sv
`timescale 1ns/1ps
module obw_datapath
  import obw_pkg::*;
#(
  parameter int NUM_WIN = OBW_MAX_WIN,
  parameter int WIDX_W  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  obwStrobe_t        strb,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  input  logic [31:0]       lookupAddr,
  output logic              miss,
  output logic [WIDX_W-1:0] hitWin,
  output logic [63:0]       pcieAddr,
  output logic [1:0]        txnType,
  output logic [7:0]        cfgBus,
  output logic [4:0]        cfgDev,
  output logic [2:0]        cfgFunc
);

  obwWin_t           winQ [NUM_WIN];
  logic [NUM_WIN-1:0] hitVec;
  logic [63:0]        xlatVec [NUM_WIN];

  // ---------------- window storage and per-window match ----------------
  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        winQ[w] <= '0;
      end else begin
        if (strb.ctrlWe[w]) begin
          winQ[w].en     <= regWrData[0];
          winQ[w].typ    <= obwType_e'(regWrData[2:1]);
          winQ[w].maskLo <= regWrData[31:OBW_GRAN_W];
        end
        if (strb.axiWe[w]) winQ[w].axiBase <= regWrData[31:2];
        if (strb.loWe[w])  winQ[w].pcieLo  <= regWrData;
        if (strb.hiWe[w])  winQ[w].pcieHi  <= regWrData;
        if (strb.szWe[w])  winQ[w].maskHi  <= regWrData;
      end
    end

    obw_winmatch u_match (
      .win  (winQ[w]),
      .addr (lookupAddr),
      .hit  (hitVec[w]),
      .xlat (xlatVec[w])
    );
  end

  // ---------------- lowest index wins ----------------
  logic [WIDX_W-1:0] selIdx;
  always_comb begin
    selIdx = '0;
    for (int w = NUM_WIN - 1; w >= 0; w--) begin
      if (hitVec[w]) selIdx = WIDX_W'(w);
    end
  end

  obwType_e selTyp;
  always_comb begin
    miss     = ~|hitVec;
    hitWin   = '0;
    pcieAddr = '0;
    selTyp   = TYP_CFG;
    if (!miss) begin
      hitWin   = selIdx;
      pcieAddr = xlatVec[selIdx];
      selTyp   = winQ[selIdx].typ;
    end
    txnType = selTyp;
    cfgBus  = '0;
    cfgDev  = '0;
    cfgFunc = '0;
    if (!miss && selTyp == TYP_CFG) begin
      cfgBus  = pcieAddr[31:24];
      cfgDev  = pcieAddr[23:19];
      cfgFunc = pcieAddr[18:16];
    end
  end

  // ---------------- register read mux ----------------
  obwWin_t rdWinSel;
  assign rdWinSel = winQ[strb.rdWin];

  always_comb begin
    unique case (strb.rdField)
      FLD_CTRL: regRdData = {rdWinSel.maskLo, {(OBW_GRAN_W-3){1'b0}},
                             rdWinSel.typ, rdWinSel.en};
      FLD_AXI:  regRdData = {rdWinSel.axiBase, 2'b00};
      FLD_PLO:  regRdData = rdWinSel.pcieLo;
      FLD_PHI:  regRdData = rdWinSel.pcieHi;
      FLD_SZHI: regRdData = rdWinSel.maskHi;
      default:  regRdData = '0;
    endcase
  end

endmodule

// File: rtl/obw_top.sv
`timescale 1ns/1ps
module obw_top
  import obw_pkg::*;
#(
  parameter int NUM_WIN = OBW_MAX_WIN,
  parameter int REG_AW  = 9,
  localparam int WIDX_W = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  input  logic [31:0]       lookupAddr,
  output logic              miss,
  output logic [WIDX_W-1:0] hitWin,
  output logic [63:0]       pcieAddr,
  output logic [1:0]        txnType,
  output logic [7:0]        cfgBus,
  output logic [4:0]        cfgDev,
  output logic [2:0]        cfgFunc
);

  obwStrobe_t strb;

  obw_regctl #(.NUM_WIN(NUM_WIN), .REG_AW(REG_AW)) u_ctl (
    .regWrEn (regWrEn),
    .regAddr (regAddr),
    .strb    (strb)
  );

  obw_datapath #(.NUM_WIN(NUM_WIN), .WIDX_W(WIDX_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .regWrData  (regWrData),
    .regRdData  (regRdData),
    .lookupAddr (lookupAddr),
    .miss       (miss),
    .hitWin     (hitWin),
    .pcieAddr   (pcieAddr),
    .txnType    (txnType),
    .cfgBus     (cfgBus),
    .cfgDev     (cfgDev),
    .cfgFunc    (cfgFunc)
  );

endmodule

// File: rtl/obw_checker.sv
`timescale 1ns/1ps
module obw_checker #(
  parameter int REG_AW = 9,
  parameter int WIDX_W = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWrEn,
  input logic [REG_AW-1:0] regAddr,
  input logic [31:0]       regRdData,
  input logic [31:0]       lookupAddr,
  input logic              miss,
  input logic [WIDX_W-1:0] hitWin,
  input logic [63:0]       pcieAddr,
  input logic [1:0]        txnType,
  input logic [7:0]        cfgBus,
  input logic [4:0]        cfgDev,
  input logic [2:0]        cfgFunc
);

  logic armed;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) armed <= 1'b0;
    else       armed <= 1'b1;
  end

  // R8: a miss carries all-zero results
  a_r8_miss_zero: assert property (@(posedge clk) disable iff (!rstN)
    miss |-> (pcieAddr == '0 && txnType == 2'd0 && hitWin == '0));

  // R7: the reserved type never wins
  a_r7_no_rsvd: assert property (@(posedge clk) disable iff (!rstN)
    !miss |-> txnType != 2'd3);

  // R9: config fields are zero unless a config window won
  a_r9_cfg_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (miss || txnType != 2'd0) |-> (cfgBus == '0 && cfgDev == '0 && cfgFunc == '0));

  // R9: config fields follow the translated address
  a_r9_cfg_slice: assert property (@(posedge clk) disable iff (!rstN)
    (!miss && txnType == 2'd0) |->
      (cfgBus == pcieAddr[31:24] && cfgDev == pcieAddr[23:19] && cfgFunc == pcieAddr[18:16]));

  // R3: AXI base reads back word aligned
  a_r3_base_align: assert property (@(posedge clk) disable iff (!rstN)
    (!regAddr[REG_AW-1] && regAddr[3:2] == 2'd1) |-> regRdData[1:0] == 2'b00);

  // R4: control bits 11:3 read as zero
  a_r4_ctrl_gap: assert property (@(posedge clk) disable iff (!rstN)
    (!regAddr[REG_AW-1] && regAddr[3:2] == 2'd0) |-> regRdData[11:3] == '0);

  // R10: without a write, a steady lookup address gives a steady result
  a_r10_hold: assert property (@(posedge clk) disable iff (!rstN)
    (armed && !$past(regWrEn) && $stable(lookupAddr)) |->
      ($stable(pcieAddr) && $stable(miss) && $stable(hitWin) && $stable(txnType)));

endmodule

bind obw_top obw_checker #(.REG_AW(REG_AW), .WIDX_W(WIDX_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .regWrEn    (regWrEn),
  .regAddr    (regAddr),
  .regRdData  (regRdData),
  .lookupAddr (lookupAddr),
  .miss       (miss),
  .hitWin     (hitWin),
  .pcieAddr   (pcieAddr),
  .txnType    (txnType),
  .cfgBus     (cfgBus),
  .cfgDev     (cfgDev),
  .cfgFunc    (cfgFunc)
);

// File: tb/obw_top_tb_top.sv
`timescale 1ns/1ps
module obw_top_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [8:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic [31:0] lookupAddr = '0;
  logic        miss;
  logic [2:0]  hitWin;
  logic [63:0] pcieAddr;
  logic [1:0]  txnType;
  logic [7:0]  cfgBus;
  logic [4:0]  cfgDev;
  logic [2:0]  cfgFunc;

  always #10 clk = ~clk;   // 50 MHz

  obw_top dut_i (
    .clk (clk), .rstN (rstN), .regWrEn (regWrEn), .regAddr (regAddr),
    .regWrData (regWrData), .regRdData (regRdData), .lookupAddr (lookupAddr),
    .miss (miss), .hitWin (hitWin), .pcieAddr (pcieAddr), .txnType (txnType),
    .cfgBus (cfgBus), .cfgDev (cfgDev), .cfgFunc (cfgFunc)
  );

  typedef struct {
    bit          isRead;
    logic [31:0] rdExp;
    bit          expMiss;
    logic [2:0]  expWin;
    logic [63:0] expAddr;
    logic [1:0]  expType;
    string       tag;
  } item_t;

  item_t queue_q[$];
  event  sampleEv;
  int    errors = 0;
  int    checks = 0;
  bit    finished = 1'b0;

  // ---------------- monitor ----------------
  initial begin
    forever begin
      @(sampleEv);
      if (queue_q.size() != 0) begin
        item_t it;
        it = queue_q.pop_front();
        checks++;
        if (it.isRead) begin
          if (regRdData !== it.rdExp) begin
            errors++;
            $display("FAIL %s: rdData actual=%h expected=%h", it.tag, regRdData, it.rdExp);
          end
        end else begin
          logic [7:0] eb; logic [4:0] ed; logic [2:0] ef;
          eb = '0; ed = '0; ef = '0;
          if (!it.expMiss && it.expType == 2'd0) begin
            eb = it.expAddr[31:24]; ed = it.expAddr[23:19]; ef = it.expAddr[18:16];
          end
          if (miss !== it.expMiss || hitWin !== it.expWin || pcieAddr !== it.expAddr ||
              txnType !== it.expType || cfgBus !== eb || cfgDev !== ed || cfgFunc !== ef) begin
            errors++;
            $display("FAIL %s: actual miss=%b win=%0d addr=%h type=%0d cfg=%h/%h/%h expected miss=%b win=%0d addr=%h type=%0d cfg=%h/%h/%h",
                     it.tag, miss, hitWin, pcieAddr, txnType, cfgBus, cfgDev, cfgFunc,
                     it.expMiss, it.expWin, it.expAddr, it.expType, eb, ed, ef);
          end
        end
      end
    end
  end

  // ---------------- driver tasks ----------------
  task automatic doWrite(input logic [8:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(posedge clk); #1;
    regWrEn = 1'b0;
  endtask

  task automatic readChk(input logic [8:0] a, input logic [31:0] e, input string tag);
    item_t it;
    @(negedge clk);
    regAddr = a;
    it = '{isRead: 1'b1, rdExp: e, expMiss: 1'b0, expWin: '0, expAddr: '0, expType: '0, tag: tag};
    queue_q.push_back(it);
    #5; ->sampleEv;
  endtask

  task automatic look(input logic [31:0] a, input bit m, input logic [2:0] w,
                      input logic [63:0] ea, input logic [1:0] t, input string tag);
    item_t it;
    @(negedge clk);
    lookupAddr = a;
    it = '{isRead: 1'b0, rdExp: '0, expMiss: m, expWin: w, expAddr: ea, expType: t, tag: tag};
    queue_q.push_back(it);
    #5; ->sampleEv;
  endtask

  task automatic lookDuringWrite(input logic [8:0] wa, input logic [31:0] wd,
                                 input logic [31:0] a, input bit m, input logic [2:0] w,
                                 input logic [63:0] ea, input logic [1:0] t, input string tag);
    item_t it;
    @(negedge clk);
    regWrEn = 1'b1; regAddr = wa; regWrData = wd; lookupAddr = a;
    it = '{isRead: 1'b0, rdExp: '0, expMiss: m, expWin: w, expAddr: ea, expType: t, tag: tag};
    queue_q.push_back(it);
    #5; ->sampleEv;
    @(posedge clk); #1;
    regWrEn = 1'b0;
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // ---------------- watchdog ----------------
  initial begin
    #(20 * 100000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish();
  end

  // ---------------- stimulus ----------------
  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state
    readChk(9'h000, 32'h0, "R1 ctrl0 after reset");
    readChk(9'h074, 32'h0, "R1 axi base win7 after reset");
    look(32'h0000_1234, 1'b1, 3'd0, 64'h0, 2'd0, "R1 R8 miss after reset");

    // window 0: config, 1 MB at 0x4000_0000, bus 1 dev 5 func 0
    doWrite(9'h000, 32'hFFF0_0FF9);
    doWrite(9'h004, 32'h4000_0003);
    doWrite(9'h008, 32'h0128_0000);
    readChk(9'h000, 32'hFFF0_0001, "R4 R2 ctrl gap bits and layout");
    readChk(9'h004, 32'h4000_0000, "R3 axi base low bits dropped");
    readChk(9'h008, 32'h0128_0000, "R2 pcie low readback");
    look(32'h4001_2344, 1'b0, 3'd0, 64'h0000_0000_0129_2344, 2'd0, "R9 R5 config hit fields");

    // window 1: memory, 64 KB at 0x4001_0000 overlapping window 0
    doWrite(9'h010, 32'hFFFF_0005);
    doWrite(9'h014, 32'h4001_0000);
    doWrite(9'h018, 32'h8000_0000);
    doWrite(9'h01C, 32'h0000_0012);
    look(32'h4001_0010, 1'b0, 3'd0, 64'h0000_0000_0129_0010, 2'd0, "R6 lowest index wins");

    // R10: disable window 0 while looking into it
    lookDuringWrite(9'h000, 32'hFFF0_0000, 32'h4001_0010,
                    1'b0, 3'd0, 64'h0000_0000_0129_0010, 2'd0, "R10 same-cycle sees old");
    look(32'h4001_0010, 1'b0, 3'd1, 64'h0000_0012_8000_0010, 2'd2, "R10 R7 R6 next cycle window 1");
    look(32'h4000_0010, 1'b1, 3'd0, 64'h0, 2'd0, "R7 disabled window never hits");

    // window 2: I/O, 4 KB at 0x5000_0000
    doWrite(9'h020, 32'hFFFF_F003);
    doWrite(9'h024, 32'h5000_0000);
    doWrite(9'h028, 32'h0000_1000);
    look(32'h5000_0ABC, 1'b0, 3'd2, 64'h0000_0000_0000_1ABC, 2'd1, "R9 io type no cfg fields");
    look(32'h5000_1000, 1'b1, 3'd0, 64'h0, 2'd0, "R4 R8 just past window end");

    // window 3: reserved type
    doWrite(9'h030, 32'hFFFF_F007);
    doWrite(9'h034, 32'h6000_0000);
    readChk(9'h030, 32'hFFFF_F007, "R4 reserved type stored");
    look(32'h6000_0010, 1'b1, 3'd0, 64'h0, 2'd0, "R7 reserved type never hits");

    // mask high registers and unmapped space
    doWrite(9'h108, 32'hFFFF_FFFF);
    readChk(9'h108, 32'hFFFF_FFFF, "R2 mask high window 2");
    readChk(9'h104, 32'h0, "R2 mask high window 1 untouched");
    doWrite(9'h1F0, 32'hDEAD_BEEF);
    readChk(9'h1F0, 32'h0, "R2 unmapped write ignored");
    look(32'h5000_0ABC, 1'b0, 3'd2, 64'h0000_0000_0000_1ABC, 2'd1, "R5 R2 io hit after extra writes");

    // window 7: memory, 64 KB at 0x7000_0000, 64-bit target
    doWrite(9'h070, 32'hFFFF_0005);
    doWrite(9'h074, 32'h7000_0000);
    doWrite(9'h078, 32'h0002_0000);
    doWrite(9'h07C, 32'h0000_ABCD);
    look(32'h7000_FFFC, 1'b0, 3'd7, 64'h0000_ABCD_0002_FFFC, 2'd2, "R5 R6 top window 64-bit");
    readChk(9'h07C, 32'h0000_ABCD, "R2 pcie high readback");

    repeat (2) @(negedge clk);
    finish();
  end

endmodule